// File: doc/BRIEF.md
# Bridge Configuration Control Registers

This block holds the bridge-specific registers of a type-1 configuration header. It stores the three bus numbers, the secondary latency timer, the I/O, memory and prefetchable address windows (base and limit, plus the upper extensions), and the bridge control word. It also returns the fixed identity fields: the capability bits in both status words, the bridge class code and the header type. A requester writes whole dwords with per-byte enables and reads dwords back through a separate combinational read port.

The block has three side effects. The first is a one-clock remap strobe after any write that touches the window registers, so that a downstream decoder reloads its windows. The second is a one-clock secondary bus reset pulse when software turns the bus-reset control bit on. The third is a forwarding-disable command that makes every window empty in a single cycle. Window address decoding and the primary bus protocol are handled elsewhere.

Top module: `bridge_cfg_top`

## Requirements
- R1: After reset, dword 6 (primary bus byte 0, secondary bus byte 1, subordinate bus byte 2, secondary latency timer byte 3) reads zero.
- R2: Reset clears the address bits of every window register but keeps the type codes. With the default parameters, dword 7 reads 0x00A00101, dword 8 reads 0x00000000 and dword 9 reads 0x00010001.
- R3: After reset, the prefetchable upper base (dword 10), the prefetchable upper limit (dword 11) and the bridge control word (dword 15 bits 31:16) read zero.
- R4: The bus-reset control bit is dword 15 bit 22. `sec_bus_reset` is high for exactly the one cycle after a write that takes this bit from 0 to 1. Writing 1 while the bit is already 1, or writing with byte enable 2 clear, gives no pulse.
- R5: `remap_strobe` is high for the one cycle after a write whose enabled bytes overlap byte addresses 0x1C–0x1D or 0x20–0x33. A byte address is 4*dword + lane. Writes to other bytes, such as 0x1E, 0x18 or 0x34, give no strobe.
- R6: One cycle after `fwd_disable`, every window base address field reads all ones, every limit address field reads zero, and both prefetchable upper registers read zero. The I/O upper 16-bit registers (dword 12), the bus numbers and the type codes do not change.
- R7: Dword 1 bits 31:16 and dword 7 bits 31:16 read 0x00A0. Dword 2 reads 0x06040000. Dword 3 reads 0x00010000 with bit 23 equal to `multifn_strap`.
- R8: The window type codes are read-only. Dword 7 bits 3:0 and 11:8 read 0x1 (32-bit I/O). Dword 8 nibbles 3:0 and 19:16 read 0. Dword 9 nibbles 3:0 and 19:16 read 0x1 (64-bit prefetchable).
- R9: A write changes only the bytes whose enable is set. Reads return the current register contents, and unimplemented dwords such as 0 and 13 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write request, accepted on the rising edge |
| cfg_waddr | input | ADDR_W | Dword index of the write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | ADDR_W | Dword index of the read |
| cfg_rdata | output | 32 | Read data (combinational) |
| fwd_disable | input | 1 | Command that empties all windows |
| multifn_strap | input | 1 | Multifunction bit reported in the header type |
| remap_strobe | output | 1 | One-cycle window reload strobe |
| sec_bus_reset | output | 1 | One-cycle secondary bus reset pulse |

## Verification
The bench looks for off-by-one errors at the edges of the overlap span. It writes byte 0x33 alone, 0x34 alone and 0x1E alone. A span that is too short or too long either misses a remap or raises a false one. It repeats a set of the bus-reset bit and a set with byte 2 masked off; a level-based or enable-blind design would pulse again. It also checks that the type code nibbles survive all-ones writes, reset and forwarding-disable, and that the I/O upper registers survive forwarding-disable. A design that cleared whole registers or overwrote them would show the wrong read value.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;

  // dword indices inside the configuration header
  localparam int unsigned DW_STATUS = 1;
  localparam int unsigned DW_CLASS  = 2;
  localparam int unsigned DW_HDR    = 3;
  localparam int unsigned DW_BUS    = 6;
  localparam int unsigned DW_IO     = 7;
  localparam int unsigned DW_MEM    = 8;
  localparam int unsigned DW_PREF   = 9;
  localparam int unsigned DW_PBU    = 10;
  localparam int unsigned DW_PLU    = 11;
  localparam int unsigned DW_IOU    = 12;
  localparam int unsigned DW_CTL    = 15;

  // byte spans that trigger a window reload
  localparam int unsigned IO_SPAN_LO  = 28;
  localparam int unsigned IO_SPAN_HI  = 29;
  localparam int unsigned MEM_SPAN_LO = 32;
  localparam int unsigned MEM_SPAN_HI = 51;

  localparam logic [15:0] CAP_STATUS = 16'h00A0;
  localparam logic [23:0] CLASS_BRG  = 24'h060400;
  localparam int unsigned SBR_BIT    = 6;

  typedef struct packed {
    logic [7:0]  pri;
    logic [7:0]  sec;
    logic [7:0]  sub;
    logic [7:0]  lat;
    logic [3:0]  io_base;
    logic [3:0]  io_lim;
    logic [11:0] mem_base;
    logic [11:0] mem_lim;
    logic [11:0] pf_base;
    logic [11:0] pf_lim;
    logic [31:0] pf_base_up;
    logic [31:0] pf_lim_up;
    logic [15:0] io_base_up;
    logic [15:0] io_lim_up;
    logic [15:0] ctl;
  } bcfg_state_t;

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic win_overlap(input int unsigned dw,
                                       input logic [3:0] be);
    logic hit;
    int unsigned a;
    hit = 1'b0;
    for (int b = 0; b < 4; b++) begin
      a = dw * 4 + b;
      if (be[b] && (((a >= IO_SPAN_LO) && (a <= IO_SPAN_HI)) ||
                    ((a >= MEM_SPAN_LO) && (a <= MEM_SPAN_HI))))
        hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
  import bridge_cfg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter bit IO_32  = 1'b1,
  parameter bit PF_64  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_dw,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic              fwd_dis,
  output bcfg_state_t       st
);

  bcfg_state_t nxt;
  logic [31:0] m;
  int unsigned dw_i;

  assign dw_i = 32'(wr_dw);

  always_comb begin
    nxt = st;
    m   = '0;
    if (wr_en) begin
      case (dw_i)
        DW_BUS: begin
          m = be_merge({st.lat, st.sub, st.sec, st.pri}, wr_data, wr_be);
          nxt.pri = m[7:0];
          nxt.sec = m[15:8];
          nxt.sub = m[23:16];
          nxt.lat = m[31:24];
        end
        DW_IO: begin
          m = be_merge({16'h0, st.io_lim, 4'h0, st.io_base, 4'h0}, wr_data, wr_be);
          nxt.io_base = m[7:4];
          nxt.io_lim  = m[15:12];
        end
        DW_MEM: begin
          m = be_merge({st.mem_lim, 4'h0, st.mem_base, 4'h0}, wr_data, wr_be);
          nxt.mem_base = m[15:4];
          nxt.mem_lim  = m[31:20];
        end
        DW_PREF: begin
          m = be_merge({st.pf_lim, 4'h0, st.pf_base, 4'h0}, wr_data, wr_be);
          nxt.pf_base = m[15:4];
          nxt.pf_lim  = m[31:20];
        end
        DW_PBU: nxt.pf_base_up = be_merge(st.pf_base_up, wr_data, wr_be);
        DW_PLU: nxt.pf_lim_up  = be_merge(st.pf_lim_up, wr_data, wr_be);
        DW_IOU: begin
          m = be_merge({st.io_lim_up, st.io_base_up}, wr_data, wr_be);
          nxt.io_base_up = m[15:0];
          nxt.io_lim_up  = m[31:16];
        end
        DW_CTL: begin
          m = be_merge({st.ctl, 16'h0}, wr_data, wr_be);
          nxt.ctl = m[31:16];
        end
        default: ;
      endcase
    end
    if (fwd_dis) begin
      nxt.io_base    = '1;
      nxt.io_lim     = '0;
      nxt.mem_base   = '1;
      nxt.mem_lim    = '0;
      nxt.pf_base    = '1;
      nxt.pf_lim     = '0;
      nxt.pf_base_up = '0;
      nxt.pf_lim_up  = '0;
    end
    if (!PF_64) begin
      nxt.pf_base_up = '0;
      nxt.pf_lim_up  = '0;
    end
    if (!IO_32) begin
      nxt.io_base_up = '0;
      nxt.io_lim_up  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= nxt;
  end

  // R6: the windows are empty once forwarding-disable takes effect
  p_fwd_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_dis |=> (&st.io_base) && (st.io_lim == '0) && (&st.mem_base) &&
                (st.mem_lim == '0) && (&st.pf_base) && (st.pf_lim == '0) &&
                (st.pf_base_up == '0) && (st.pf_lim_up == '0));

  // R6: forwarding-disable keeps the I/O upper registers
  p_fwd_keeps_iou_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_dis && !(wr_en && dw_i == DW_IOU)) |=>
      $stable(st.io_base_up) && $stable(st.io_lim_up));

endmodule

// File: rtl/bridge_cfg_events.sv
module bridge_cfg_events
  import bridge_cfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_dw,
  input  logic [3:0]        wr_be,
  input  logic              wr_sbr_set,
  input  logic              cur_sbr,
  output logic              remap,
  output logic              sbr_pulse
);

  logic ev_remap_d;
  logic ev_sbr_d;

  assign ev_remap_d = wr_en && win_overlap(32'(wr_dw), wr_be);
  assign ev_sbr_d   = wr_en && (32'(wr_dw) == DW_CTL) && wr_sbr_set && !cur_sbr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap     <= 1'b0;
      sbr_pulse <= 1'b0;
    end else begin
      remap     <= ev_remap_d;
      sbr_pulse <= ev_sbr_d;
    end
  end

  // R4: a pulse only follows a 0 to 1 change of the control bit
  p_sbr_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sbr_pulse |-> (cur_sbr && !$past(cur_sbr)));

  // R4: the pulse is one cycle wide
  p_sbr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sbr_pulse |=> !sbr_pulse);

  // R5: a strobe always comes from a write in the previous cycle
  p_remap_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    remap |-> $past(wr_en));

endmodule

// File: rtl/bridge_cfg_rdmux.sv
module bridge_cfg_rdmux
  import bridge_cfg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter bit IO_32  = 1'b1,
  parameter bit PF_64  = 1'b1
) (
  input  bcfg_state_t       st,
  input  logic [ADDR_W-1:0] rd_dw,
  input  logic              multifn,
  output logic [31:0]       rdata
);

  localparam logic [3:0] IO_T = IO_32 ? 4'h1 : 4'h0;
  localparam logic [3:0] PF_T = PF_64 ? 4'h1 : 4'h0;

  always_comb begin
    case (32'(rd_dw))
      DW_STATUS: rdata = {CAP_STATUS, 16'h0};
      DW_CLASS:  rdata = {CLASS_BRG, 8'h00};
      DW_HDR:    rdata = {8'h00, multifn, 7'h01, 16'h0};
      DW_BUS:    rdata = {st.lat, st.sub, st.sec, st.pri};
      DW_IO:     rdata = {CAP_STATUS, st.io_lim, IO_T, st.io_base, IO_T};
      DW_MEM:    rdata = {st.mem_lim, 4'h0, st.mem_base, 4'h0};
      DW_PREF:   rdata = {st.pf_lim, PF_T, st.pf_base, PF_T};
      DW_PBU:    rdata = st.pf_base_up;
      DW_PLU:    rdata = st.pf_lim_up;
      DW_IOU:    rdata = {st.io_lim_up, st.io_base_up};
      DW_CTL:    rdata = {st.ctl, 16'h0};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/bridge_cfg_top.sv
module bridge_cfg_top
  import bridge_cfg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter bit IO_32  = 1'b1,
  parameter bit PF_64  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_waddr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic              fwd_disable,
  input  logic              multifn_strap,
  output logic              remap_strobe,
  output logic              sec_bus_reset
);

  localparam logic [3:0] IO_T = IO_32 ? 4'h1 : 4'h0;

  bcfg_state_t st;
  logic        wr_sbr_set;

  assign wr_sbr_set = cfg_be[2] && cfg_wdata[16 + SBR_BIT];

  bridge_cfg_regs #(.ADDR_W(ADDR_W), .IO_32(IO_32), .PF_64(PF_64)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_dw   (cfg_waddr),
    .wr_be   (cfg_be),
    .wr_data (cfg_wdata),
    .fwd_dis (fwd_disable),
    .st      (st)
  );

  bridge_cfg_events #(.ADDR_W(ADDR_W)) u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_dw      (cfg_waddr),
    .wr_be      (cfg_be),
    .wr_sbr_set (wr_sbr_set),
    .cur_sbr    (st.ctl[SBR_BIT]),
    .remap      (remap_strobe),
    .sbr_pulse  (sec_bus_reset)
  );

  bridge_cfg_rdmux #(.ADDR_W(ADDR_W), .IO_32(IO_32), .PF_64(PF_64)) u_rdmux (
    .st      (st),
    .rd_dw   (cfg_raddr),
    .multifn (multifn_strap),
    .rdata   (cfg_rdata)
  );

  // R8: I/O type codes read back fixed whatever was written
  p_io_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_raddr) == DW_IO) |-> (cfg_rdata[3:0] == IO_T) && (cfg_rdata[11:8] == IO_T));

  // R7: primary status capability bits
  p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_raddr) == DW_STATUS) |-> (cfg_rdata == 32'h00A0_0000));

endmodule

// File: tb/tb_bridge_cfg_top.sv
module tb_bridge_cfg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_waddr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        fwd_disable = 1'b0;
  logic        multifn_strap = 1'b0;
  logic        remap_strobe;
  logic        sec_bus_reset;

  int checks = 0;
  int fails  = 0;
  logic got_remap, got_sbr;

  always #2 clk = ~clk;

  bridge_cfg_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata), .fwd_disable(fwd_disable),
    .multifn_strap(multifn_strap), .remap_strobe(remap_strobe),
    .sec_bus_reset(sec_bus_reset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input int dw, input logic [31:0] exp);
    @(negedge clk);
    cfg_raddr = 6'(dw);
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  // write; records strobe and pulse in the cycle after the write, checks they drop next
  task automatic wr(input int dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = 6'(dw); cfg_be = be; cfg_wdata = d;
    @(posedge clk);
    #1;
    got_remap = remap_strobe;
    got_sbr   = sec_bus_reset;
    @(negedge clk);
    cfg_we = 1'b0;
    @(posedge clk);
    #1;
    chk("R5 strobe one cycle", {31'h0, remap_strobe}, 32'h0);
    chk("R4 pulse one cycle", {31'h0, sec_bus_reset}, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    rd_chk("R1 bus numbers", 6, 32'h0);
    rd_chk("R2 io window", 7, 32'h00A0_0101);
    rd_chk("R2 mem window", 8, 32'h0);
    rd_chk("R2 pref window", 9, 32'h0001_0001);
    rd_chk("R3 pref upper base", 10, 32'h0);
    rd_chk("R3 pref upper limit", 11, 32'h0);
    rd_chk("R3 bridge control", 15, 32'h0);
    chk("R4 no pulse at reset", {31'h0, sec_bus_reset}, 32'h0);
  endtask

  task automatic t_ident();
    rd_chk("R7 status", 1, 32'h00A0_0000);
    rd_chk("R7 class", 2, 32'h0604_0000);
    rd_chk("R7 header mf=0", 3, 32'h0001_0000);
    multifn_strap = 1'b1;
    rd_chk("R7 header mf=1", 3, 32'h0081_0000);
    multifn_strap = 1'b0;
    rd_chk("R9 unimplemented dw0", 0, 32'h0);
  endtask

  task automatic t_bytes();
    wr(6, 4'b0101, 32'h4433_2211);
    chk("R5 no strobe bus write", {31'h0, got_remap}, 32'h0);
    rd_chk("R9 byte enables", 6, 32'h0033_0011);
  endtask

  task automatic t_windows();
    wr(7, 4'b0011, 32'hFFFF_F2F3);
    chk("R5 strobe io write", {31'h0, got_remap}, 32'h1);
    rd_chk("R8 io type kept", 7, 32'h00A0_F1F1);
    wr(7, 4'b1100, 32'h1234_0000);
    chk("R5 no strobe byte 0x1E", {31'h0, got_remap}, 32'h0);
    rd_chk("R7 sec status ro", 7, 32'h00A0_F1F1);
    wr(8, 4'b1111, 32'h1235_ABCF);
    chk("R5 strobe mem write", {31'h0, got_remap}, 32'h1);
    rd_chk("R8 mem type zero", 8, 32'h1230_ABC0);
    wr(9, 4'b1111, 32'hFFFF_FFFF);
    rd_chk("R8 pref type kept", 9, 32'hFFF1_FFF1);
    wr(12, 4'b1000, 32'h5500_0000);
    chk("R5 strobe byte 0x33", {31'h0, got_remap}, 32'h1);
    wr(13, 4'b0001, 32'h0000_00FF);
    chk("R5 no strobe byte 0x34", {31'h0, got_remap}, 32'h0);
    rd_chk("R9 unimplemented dw13", 13, 32'h0);
    wr(12, 4'b0111, 32'h0055_AAAA);
    rd_chk("R9 io upper", 12, 32'h5555_AAAA);
    wr(10, 4'b1111, 32'h1234_5678);
    rd_chk("R9 pref upper", 10, 32'h1234_5678);
    wr(11, 4'b1111, 32'h9ABC_DEF0);
  endtask

  task automatic t_sbr();
    wr(15, 4'b1000, 32'h0040_0000);
    chk("R4 masked byte no pulse", {31'h0, got_sbr}, 32'h0);
    wr(15, 4'b0100, 32'h0040_0000);
    chk("R4 pulse on rise", {31'h0, got_sbr}, 32'h1);
    rd_chk("R4 control bit set", 15, 32'h0040_0000);
    wr(15, 4'b0100, 32'h0040_0000);
    chk("R4 no pulse when already set", {31'h0, got_sbr}, 32'h0);
    wr(15, 4'b0100, 32'h0);
    chk("R4 no pulse on fall", {31'h0, got_sbr}, 32'h0);
    wr(15, 4'b0100, 32'h0040_0000);
    chk("R4 pulse on second rise", {31'h0, got_sbr}, 32'h1);
  endtask

  task automatic t_fwd();
    @(negedge clk);
    fwd_disable = 1'b1;
    @(negedge clk);
    fwd_disable = 1'b0;
    rd_chk("R6 io window empty", 7, 32'h00A0_01F1);
    rd_chk("R6 mem window empty", 8, 32'h0000_FFF0);
    rd_chk("R6 pref window empty", 9, 32'h0001_FFF1);
    rd_chk("R6 pref upper base", 10, 32'h0);
    rd_chk("R6 pref upper limit", 11, 32'h0);
    rd_chk("R6 io upper kept", 12, 32'h5555_AAAA);
    rd_chk("R6 bus numbers kept", 6, 32'h0033_0011);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_bytes();
    t_windows();
    t_sbr();
    t_fwd();
    do_reset();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule